// File: doc/BRIEF.md
# Fixed-Point Matrix-Vector Multiply-Add Unit

This block is the transform stage of a geometry coprocessor. Every operation multiplies a signed 3x3 matrix of 16-bit elements by a signed 3-element vector of 16-bit elements and adds a 32-bit translation vector. The translation is scaled by 2^12, so it lines up with the fractional part of the products. A command word chooses the matrix, the source vector and the translation from flat bank inputs. Each of these fields has a select code that needs no bank: code 3 gives a zero matrix, a zero translation, or the current intermediate registers as the source vector.

Each row sum is kept at full precision. It can be scaled down by 2^12 and is then saturated into a 32-bit accumulator. The accumulator is clamped into a 16-bit intermediate result, and the lower limit of that clamp can be raised to zero. A status word reports full-precision overflow and any clamping. The register file that holds the operands sits outside the block. It presents its contents on the flat inputs and takes the results when `done_o` pulses.

Top module: `mvma_unit`

## Requirements
- R1: Command bits 18:17 pick one of three matrix banks (bank b, row r, column c at element index b*9+r*3+c of `mat_i`). Code 3 uses an all-zero matrix.
- R2: Command bits 16:15 pick one of three vector banks (bank b, element k at index b*3+k of `vec_i`). Code 3 uses the three entries of `ir_i` instead.
- R3: Command bits 14:13 pick one of three translation banks (bank b, row r at 32-bit index b*3+r of `trans_i`). The translation enters the row sum multiplied by 4096, and code 3 gives a zero translation.
- R4: Each row sum is the exact sum of three signed 16x16 products plus the scaled translation, with no loss below 44 bits. When command bit 19 is 1, the sum is shifted arithmetically right by 12 before it is stored. When bit 19 is 0, it is stored as computed.
- R5: Each accumulator output (`mac_o` row r at bits r*32 upward) is the stored value saturated to the signed 32-bit range.
- R6: Each intermediate output is its accumulator saturated to -32768..32767. When command bit 10 is 1, the range is 0..32767 instead.
- R7: Flag bits 24, 23 and 22 are set when the intermediate result of row 0, row 1 or row 2 had to be clamped.
- R8: Flag bits 30, 29 and 28 mark rows 0, 1 and 2 whose unshifted sum exceeds 2^43-1. Flag bits 27, 26 and 25 mark rows 0, 1 and 2 whose unshifted sum is below -2^43.
- R9: Flag bit 31 is the OR of flag bits 30 down to 23, so a row 2 clamp alone leaves it clear. Flag bits 21..0 are always zero.
- R10: A start pulse sampled on a clock edge gives results and a one-cycle `done_o` three edges later. The outputs then hold their values until the next result.
- R11: The flag word reads zero from the edge that samples a start until that operation's result is written, unless an earlier operation completes in between.
- R12: After an asynchronous reset, `done_o`, the accumulators, the intermediate results and the flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation with the current command and operands |
| cmd_i | input | 32 | Command word: selects, shift flag, lower-limit flag |
| mat_i | input | 432 | Three matrix banks, nine 16-bit elements each |
| trans_i | input | 288 | Three translation banks, three 32-bit entries each |
| vec_i | input | 144 | Three vector banks, three 16-bit elements each |
| ir_i | input | 48 | Current intermediate registers, used by vector select 3 |
| done_o | output | 1 | One-cycle pulse when the results are valid |
| mac_o | output | 96 | Three saturated 32-bit accumulators |
| ir_o | output | 48 | Three clamped 16-bit intermediate results |
| flag_o | output | 32 | Status flags for the last operation |

## Verification
The bench uses the default widths: 16-bit elements, 32-bit translations and accumulators, a 44-bit overflow bound and a 12-bit fraction. With these widths, the worst-case operands fit in 64-bit bench arithmetic and still reach the 44-bit overflow limit. All-0x8000 operands with the largest translation cross the positive bound, and mixed extremes with the smallest translation cross the negative one. These operands also reach 32-bit accumulator saturation and 16-bit clamping at both ends. Each select field is tried at all four codes, in combination with both shift settings and both lower-limit settings.

// File: rtl/mvma_pkg.sv
package mvma_pkg;
  // command fields
  localparam int CMD_SF    = 19;
  localparam int CMD_MX_LO = 17;
  localparam int CMD_V_LO  = 15;
  localparam int CMD_CV_LO = 13;
  localparam int CMD_LM    = 10;
  // flag fields, row r sits at *_HI - r
  localparam int FLG_SUM    = 31;
  localparam int FLG_OVP_HI = 30;
  localparam int FLG_OVN_HI = 27;
  localparam int FLG_IRC_HI = 24;
  localparam int FLG_IRC_LO = 22;

  localparam int NROW = 3;
  typedef logic [1:0] sel_t;
  localparam sel_t SEL_NONE = 2'd3;
endpackage

// File: rtl/mvma_operand_sel.sv
module mvma_operand_sel
  import mvma_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 32
) (
  input  logic [3*9*DW-1:0] mat_i,
  input  logic [3*3*DW-1:0] vec_i,
  input  logic [3*3*TW-1:0] trans_i,
  input  logic [3*DW-1:0]   ir_i,
  input  sel_t              mx_i,
  input  sel_t              v_i,
  input  sel_t              cv_i,
  output logic [9*DW-1:0]   mat_o,
  output logic [3*DW-1:0]   vec_o,
  output logic [3*TW-1:0]   trans_o
);
  localparam int MATW = 9*DW;
  localparam int VECW = 3*DW;
  localparam int TRW  = 3*TW;

  always_comb begin
    mat_o   = '0;
    trans_o = '0;
    vec_o   = ir_i;
    if (mx_i != SEL_NONE) mat_o   = mat_i[int'(mx_i)*MATW +: MATW];
    if (cv_i != SEL_NONE) trans_o = trans_i[int'(cv_i)*TRW +: TRW];
    if (v_i  != SEL_NONE) vec_o   = vec_i[int'(v_i)*VECW +: VECW];
  end
endmodule

// File: rtl/mvma_row.sv
module mvma_row #(
  parameter int DW   = 16,
  parameter int TW   = 32,
  parameter int FRAC = 12,
  parameter int SW   = 48
) (
  input  logic [3*DW-1:0]        row_i,
  input  logic [3*DW-1:0]        vec_i,
  input  logic [TW-1:0]          trans_i,
  output logic signed [SW-1:0]   sum_o
);
  localparam int PW = 2*DW;

  logic signed [PW-1:0] prod;

  always_comb begin
    sum_o = {{(SW-TW){trans_i[TW-1]}}, trans_i} << FRAC;
    prod  = '0;
    for (int k = 0; k < 3; k++) begin
      prod  = $signed(row_i[k*DW +: DW]) * $signed(vec_i[k*DW +: DW]);
      sum_o = sum_o + {{(SW-PW){prod[PW-1]}}, prod};
    end
  end
endmodule

// File: rtl/mvma_clamp.sv
module mvma_clamp #(
  parameter int SW   = 48,
  parameter int ACCW = 44,
  parameter int MACW = 32,
  parameter int DW   = 16,
  parameter int FRAC = 12
) (
  input  logic signed [SW-1:0] sum_i,
  input  logic                 sf_i,
  input  logic                 lm_i,
  output logic [MACW-1:0]      mac_o,
  output logic [DW-1:0]        ir_o,
  output logic                 ovp_o,
  output logic                 ovn_o,
  output logic                 irc_o
);
  localparam logic signed [SW-1:0]   ACC_MAX = {{(SW-ACCW+1){1'b0}}, {(ACCW-1){1'b1}}};
  localparam logic signed [SW-1:0]   ACC_MIN = ~ACC_MAX;
  localparam logic signed [SW-1:0]   MAC_MAX = {{(SW-MACW+1){1'b0}}, {(MACW-1){1'b1}}};
  localparam logic signed [SW-1:0]   MAC_MIN = ~MAC_MAX;
  localparam logic signed [MACW-1:0] IR_MAX  = {{(MACW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [MACW-1:0] IR_MIN  = ~IR_MAX;

  logic signed [SW-1:0]   sh;
  logic signed [MACW-1:0] mac_s;
  logic signed [MACW-1:0] lo;

  always_comb begin
    ovp_o = sum_i > ACC_MAX;
    ovn_o = sum_i < ACC_MIN;
    sh    = sf_i ? (sum_i >>> FRAC) : sum_i;
    if (sh > MAC_MAX)      mac_s = MAC_MAX[MACW-1:0];
    else if (sh < MAC_MIN) mac_s = MAC_MIN[MACW-1:0];
    else                   mac_s = sh[MACW-1:0];
    mac_o = mac_s;
    lo    = lm_i ? '0 : IR_MIN;
    irc_o = 1'b1;
    if (mac_s > IR_MAX)  ir_o = IR_MAX[DW-1:0];
    else if (mac_s < lo) ir_o = lo[DW-1:0];
    else begin
      ir_o  = mac_s[DW-1:0];
      irc_o = 1'b0;
    end
  end
endmodule

// File: rtl/mvma_unit.sv
module mvma_unit
  import mvma_pkg::*;
#(
  parameter int DW   = 16,
  parameter int TW   = 32,
  parameter int MACW = 32,
  parameter int ACCW = 44,
  parameter int FRAC = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [31:0]          cmd_i,
  input  logic [3*9*DW-1:0]    mat_i,
  input  logic [3*3*TW-1:0]    trans_i,
  input  logic [3*3*DW-1:0]    vec_i,
  input  logic [3*DW-1:0]      ir_i,
  output logic                 done_o,
  output logic [NROW*MACW-1:0] mac_o,
  output logic [NROW*DW-1:0]   ir_o,
  output logic [31:0]          flag_o
);
  localparam int SW   = ACCW + 4;
  localparam int MATW = 9*DW;
  localparam int VECW = 3*DW;
  localparam int TRW  = 3*TW;

  logic unused_cmd;
  assign unused_cmd = ^{cmd_i[31:20], cmd_i[12:11], cmd_i[9:0]};

  // stage 1: operand capture
  logic [MATW-1:0] sel_mat, s1_mat;
  logic [VECW-1:0] sel_vec, s1_vec;
  logic [TRW-1:0]  sel_tr,  s1_tr;
  logic            s1_vld, s1_sf, s1_lm;

  mvma_operand_sel #(.DW(DW), .TW(TW)) u_sel (
    .mat_i   (mat_i),
    .vec_i   (vec_i),
    .trans_i (trans_i),
    .ir_i    (ir_i),
    .mx_i    (cmd_i[CMD_MX_LO +: 2]),
    .v_i     (cmd_i[CMD_V_LO +: 2]),
    .cv_i    (cmd_i[CMD_CV_LO +: 2]),
    .mat_o   (sel_mat),
    .vec_o   (sel_vec),
    .trans_o (sel_tr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s1_sf  <= 1'b0;
      s1_lm  <= 1'b0;
      s1_mat <= '0;
      s1_vec <= '0;
      s1_tr  <= '0;
    end else begin
      s1_vld <= start_i;
      if (start_i) begin
        s1_sf  <= cmd_i[CMD_SF];
        s1_lm  <= cmd_i[CMD_LM];
        s1_mat <= sel_mat;
        s1_vec <= sel_vec;
        s1_tr  <= sel_tr;
      end
    end
  end

  // stage 2: full-precision row sums
  logic signed [SW-1:0] sum_w [NROW];
  logic signed [SW-1:0] s2_sum [NROW];
  logic                 s2_vld, s2_sf, s2_lm;

  // stage 3 comb: shift, saturate, clamp
  logic [MACW-1:0]  mac_n [NROW];
  logic [DW-1:0]    ir_n  [NROW];
  logic [NROW-1:0]  ovp, ovn, irc;

  for (genvar r = 0; r < NROW; r++) begin : g_row
    mvma_row #(.DW(DW), .TW(TW), .FRAC(FRAC), .SW(SW)) u_row (
      .row_i   (s1_mat[r*VECW +: VECW]),
      .vec_i   (s1_vec),
      .trans_i (s1_tr[r*TW +: TW]),
      .sum_o   (sum_w[r])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     s2_sum[r] <= '0;
      else if (s1_vld) s2_sum[r] <= sum_w[r];
    end

    mvma_clamp #(.SW(SW), .ACCW(ACCW), .MACW(MACW), .DW(DW), .FRAC(FRAC)) u_clamp (
      .sum_i (s2_sum[r]),
      .sf_i  (s2_sf),
      .lm_i  (s2_lm),
      .mac_o (mac_n[r]),
      .ir_o  (ir_n[r]),
      .ovp_o (ovp[r]),
      .ovn_o (ovn[r]),
      .irc_o (irc[r])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mac_o[r*MACW +: MACW] <= '0;
        ir_o[r*DW +: DW]      <= '0;
      end else if (s2_vld) begin
        mac_o[r*MACW +: MACW] <= mac_n[r];
        ir_o[r*DW +: DW]      <= ir_n[r];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld <= 1'b0;
      s2_sf  <= 1'b0;
      s2_lm  <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_sf <= s1_sf;
        s2_lm <= s1_lm;
      end
    end
  end

  logic [31:0] flag_n;

  always_comb begin
    flag_n = '0;
    for (int r = 0; r < NROW; r++) begin
      flag_n[FLG_OVP_HI-r] = ovp[r];
      flag_n[FLG_OVN_HI-r] = ovn[r];
      flag_n[FLG_IRC_HI-r] = irc[r];
    end
    // row 2 clamp is excluded from the summary bit
    flag_n[FLG_SUM] = |flag_n[FLG_OVP_HI:FLG_IRC_LO+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      flag_o <= '0;
    end else begin
      done_o <= s2_vld;
      if (s2_vld)       flag_o <= flag_n;
      else if (start_i) flag_o <= '0;
    end
  end
endmodule

// File: rtl/mvma_unit_chk.sv
module mvma_unit_chk #(
  parameter int DW   = 16,
  parameter int MACW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              lm_i,
  input logic              done_o,
  input logic [3*MACW-1:0] mac_o,
  input logic [3*DW-1:0]   ir_o,
  input logic [31:0]       flag_o
);
  logic [2:0] st_sh;
  logic [2:0] lm_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_sh <= '0;
      lm_sh <= '0;
    end else begin
      st_sh <= {st_sh[1:0], start_i};
      lm_sh <= {lm_sh[1:0], start_i & lm_i};
    end
  end

  a_r10_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == st_sh[2]);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(mac_o) && $stable(ir_o)));

  a_r11_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !st_sh[1]) |=> (flag_o == '0));

  a_r9_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flag_o[31] == |flag_o[30:23]));

  a_r9_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o[21:0] == '0);

  for (genvar r = 0; r < 3; r++) begin : g_row
    a_r6_lm_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && lm_sh[2]) |-> !ir_o[r*DW + DW-1]);

    a_r7_no_clamp_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !flag_o[24-r]) |-> (ir_o[r*DW +: DW] == mac_o[r*MACW +: DW]));
  end
endmodule

bind mvma_unit mvma_unit_chk #(.DW(DW), .MACW(MACW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .lm_i    (cmd_i[10]),
  .done_o  (done_o),
  .mac_o   (mac_o),
  .ir_o    (ir_o),
  .flag_o  (flag_o)
);

// File: tb/tb_mvma_unit.sv
module tb_mvma_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  cmd = '0;
  logic [431:0] mat = '0;
  logic [287:0] tr = '0;
  logic [143:0] vec = '0;
  logic [47:0]  irin = '0;
  logic         done;
  logic [95:0]  mac;
  logic [47:0]  ir;
  logic [31:0]  flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [95:0] exp_mac;
  logic [47:0] exp_ir;
  logic [31:0] exp_flag;

  always #2 clk = ~clk;

  mvma_unit dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .cmd_i (cmd),
    .mat_i (mat), .trans_i (tr), .vec_i (vec), .ir_i (irin),
    .done_o (done), .mac_o (mac), .ir_o (ir), .flag_o (flag)
  );

  // {sf, mx, v, cv, lm, operand set}
  localparam logic [9:0] TBL [16] = '{
    {1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd1, 2'd1, 2'd1, 1'b0, 2'd3},
    {1'b1, 2'd2, 2'd2, 2'd2, 1'b1, 2'd0},
    {1'b1, 2'd3, 2'd0, 2'd0, 1'b0, 2'd0},
    {1'b1, 2'd0, 2'd3, 2'd1, 1'b0, 2'd0},
    {1'b1, 2'd1, 2'd2, 2'd3, 1'b0, 2'd0},
    {1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0},
    {1'b0, 2'd2, 2'd1, 2'd0, 1'b1, 2'd0},
    {1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd1},
    {1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 2'd1},
    {1'b0, 2'd1, 2'd2, 2'd1, 1'b0, 2'd2},
    {1'b1, 2'd2, 2'd2, 2'd2, 1'b1, 2'd2},
    {1'b1, 2'd3, 2'd3, 2'd3, 1'b0, 2'd0},
    {1'b0, 2'd3, 2'd1, 2'd2, 1'b1, 2'd3},
    {1'b1, 2'd1, 2'd3, 2'd0, 1'b1, 2'd3},
    {1'b0, 2'd2, 2'd3, 2'd3, 1'b0, 2'd0}
  };

  task automatic chk(string tag, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] mval(int s, int i);
    case (s)
      0: return 16'(i*4513 + 777);
      1: return 16'h8000;
      2: return 16'h7FFF;
      default: return 16'(i - 4);
    endcase
  endfunction

  function automatic logic [15:0] vval(int s, int i);
    case (s)
      0: return 16'(i*2371 - 9000);
      1, 2: return 16'h8000;
      default: return 16'(i + 1);
    endcase
  endfunction

  function automatic logic [31:0] tval(int s, int i);
    case (s)
      0: return 32'(i*123457 - 300000);
      1: return 32'h7FFFFFFF;
      2: return 32'h80000000;
      default: return 32'(2*i - 3);
    endcase
  endfunction

  function automatic logic [15:0] ival(int s, int i);
    case (s)
      0: return 16'(i*9001 + 5);
      1: return 16'h8000;
      2: return 16'h7FFF;
      default: return 16'(5 - i);
    endcase
  endfunction

  task automatic load_set(int s);
    for (int i = 0; i < 27; i++) mat[i*16 +: 16] = mval(s, i);
    for (int i = 0; i < 9; i++) begin
      vec[i*16 +: 16] = vval(s, i);
      tr[i*32 +: 32]  = tval(s, i);
    end
    for (int i = 0; i < 3; i++) irin[i*16 +: 16] = ival(s, i);
  endtask

  // reference model of R1..R9
  task automatic model(logic [31:0] c);
    int mx, vs, cv;
    longint s, m, v, lo, mc, iv;
    mx = int'(c[18:17]); vs = int'(c[16:15]); cv = int'(c[14:13]);
    exp_flag = '0;
    for (int r = 0; r < 3; r++) begin
      s = 0;
      if (cv != 3) s = longint'($signed(tr[(cv*3+r)*32 +: 32])) * 4096;
      for (int k = 0; k < 3; k++) begin
        m = (mx == 3) ? 0 : longint'($signed(mat[(mx*9+r*3+k)*16 +: 16]));
        v = (vs == 3) ? longint'($signed(irin[k*16 +: 16]))
                      : longint'($signed(vec[(vs*3+k)*16 +: 16]));
        s += m * v;
      end
      if (s > 64'sd8796093022207)  exp_flag[30-r] = 1'b1;
      if (s < -64'sd8796093022208) exp_flag[27-r] = 1'b1;
      if (c[19]) s = s >>> 12;
      mc = s;
      if (mc > 64'sd2147483647)  mc = 64'sd2147483647;
      if (mc < -64'sd2147483648) mc = -64'sd2147483648;
      lo = c[10] ? 0 : -32768;
      iv = mc;
      if (iv > 32767) iv = 32767;
      if (iv < lo)    iv = lo;
      if (iv != mc) exp_flag[24-r] = 1'b1;
      exp_mac[r*32 +: 32] = mc[31:0];
      exp_ir[r*16 +: 16]  = iv[15:0];
    end
    exp_flag[31] = |exp_flag[30:23];
  endtask

  task automatic run_op(logic [31:0] c, string tag);
    model(c);
    @(negedge clk);
    cmd = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R11 flag cleared"}, 128'(flag), 128'(0));
    chk({tag, " R10 no early done"}, 128'(done), 128'(0));
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R10 done"}, 128'(done), 128'(1));
    chk({tag, " R4/R5 mac"}, 128'(mac), 128'(exp_mac));
    chk({tag, " R6 ir"}, 128'(ir), 128'(exp_ir));
    chk({tag, " R7/R8/R9 flag"}, 128'(flag), 128'(exp_flag));
    @(negedge clk);
    chk({tag, " R10 done single"}, 128'(done), 128'(0));
  endtask

  initial begin
    #(4*100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] e;
    logic [31:0] c;
    string tag;
    @(negedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12 done", 128'(done), 128'(0));
    chk("R12 mac", 128'(mac), 128'(0));
    chk("R12 ir", 128'(ir), 128'(0));
    chk("R12 flag", 128'(flag), 128'(0));
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      e = TBL[i];
      load_set(int'(e[1:0]));
      c = '0;
      c[19] = e[9]; c[18:17] = e[8:7]; c[16:15] = e[6:5]; c[14:13] = e[4:3]; c[10] = e[2];
      c[31:20] = 12'hA5C; c[12:11] = 2'b11; c[9:0] = 10'h2B3; // don't-care bits
      if (e[8:7] == 2'd3)      tag = "R1";
      else if (e[6:5] == 2'd3) tag = "R2";
      else if (e[4:3] == 2'd3) tag = "R3";
      else                     tag = "R4";
      run_op(c, $sformatf("%s vec%0d", tag, i));
    end

    // R10 outputs hold with no start
    exp_mac = mac;
    repeat (5) @(negedge clk);
    chk("R10 hold mac", 128'(mac), 128'(exp_mac));
    chk("R10 no spurious done", 128'(done), 128'(0));

    // R8 positive overflow row 0, shift on, limit on
    load_set(1);
    c = '0; c[19] = 1'b1; c[10] = 1'b1;
    run_op(c, "R8 pos");
    // R6 limit clamps a negative result to zero
    load_set(2);
    c = '0; c[10] = 1'b1; c[18:17] = 2'd1;
    run_op(c, "R6 lm");

    // R12 reset in flight drops the operation
    load_set(0);
    @(negedge clk);
    cmd = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 mid reset mac", 128'(mac), 128'(0));
    chk("R12 mid reset flag", 128'(flag), 128'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 no done after reset", 128'(done), 128'(0));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule